// File: doc/BRIEF.md
# VLAN Membership Filter with Parity Protection

This block keeps a 4096-entry VLAN membership bitmap. The bitmap is stored as 128 words of 32 member bits. Each word also holds four parity bits, one for each byte of the word. A host port writes table words and reads them back. The same host port loads a small control register, which holds the parity-check enable, the parity debug-write mode and an implicit VLAN ID with its valid flag.

A lookup port takes a 12-bit VLAN ID, or a flag marking the frame as untagged. One cycle later it answers member or not-member, together with a parity-error flag for the table word it read. Untagged frames are checked against the implicit VLAN ID when that ID is marked valid. When the implicit ID is not valid, untagged frames pass.

When a lookup finds a parity error, the block records the word address and sets a sticky interrupt bit. The first address stays recorded until the host clears the interrupt by writing a one.

Top module: `vlan_member_filter`

## Requirements
- R1: A lookup request for VLAN ID v reads word v[11:5] and returns bit v[4:0] of that word on lk_member, with lk_valid high, in the cycle after the request.
- R2: When debug-write mode is off, a table write stores parity bit i so that member bits [8i+7:8i] together with parity bit i hold an odd number of ones. A host read returns the stored member word and parity in the cycle after the address is presented.
- R3: When debug-write mode is on, a table write stores host_wr_par unchanged as the parity bits.
- R4: lk_par_err is 1 when the parity check is enabled and any byte of the word read fails odd parity. When the parity check is disabled, lk_par_err is always 0.
- R5: For an untagged frame with the implicit ID valid, the lookup uses the implicit VLAN ID in place of lk_vid.
- R6: For an untagged frame with the implicit ID not valid, the lookup returns lk_member=1 and lk_par_err=0.
- R7: A lookup parity error sets par_irq. If the log is empty, it also loads par_log_addr with the 7-bit word address, zero-extended to 12 bits. Both updates are visible in the same cycle as lk_valid.
- R8: While par_irq is set and no clear is requested, par_irq stays at 1 and later parity errors leave par_log_addr unchanged.
- R9: irq_clr=1 clears par_irq and sets par_log_addr to 0 on the next cycle. If a parity error happens in that same cycle, the error wins: par_irq stays at 1 and the log takes the new word address.
- R10: When a host write and a lookup hit the same word in the same cycle, the lookup returns the word's old contents. A host read of that address in that cycle also returns the old contents.
- R11: After reset, lk_valid=0, par_irq=0 and par_log_addr=0. The control register also clears: parity check off, debug-write mode off, implicit ID not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Table word write strobe |
| host_addr | input | 7 | Table word address for write and read |
| host_wr_member | input | 32 | Member bits to write |
| host_wr_par | input | 4 | Parity bits to write in debug-write mode |
| host_rd_member | output | 32 | Member bits read from the previous cycle's host_addr |
| host_rd_par | output | 4 | Parity bits read from the previous cycle's host_addr |
| cfg_wr_en | input | 1 | Control register load strobe |
| cfg_chk_en | input | 1 | Parity check enable |
| cfg_dbg_wr | input | 1 | Debug-write mode: parity comes from host_wr_par |
| cfg_imp_valid | input | 1 | Implicit VLAN ID valid |
| cfg_imp_vid | input | 12 | Implicit VLAN ID for untagged frames |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt bit and the log |
| lk_req | input | 1 | Lookup request |
| lk_untagged | input | 1 | Frame carries no VLAN tag |
| lk_vid | input | 12 | VLAN ID of a tagged frame |
| lk_valid | output | 1 | Lookup result valid |
| lk_member | output | 1 | Frame's VLAN is a member |
| lk_par_err | output | 1 | Parity error in the word read |
| par_irq | output | 1 | Sticky parity-error interrupt |
| par_log_addr | output | 12 | Word address of the first logged parity error |

## Verification
- A wrong bit or parity value in the table shows at the ports within two cycles: on host_rd_member and host_rd_par one cycle after its address is presented, and on lk_member or lk_par_err one cycle after a lookup of any VLAN in that word.
- A wrong error-log state shows on par_irq or par_log_addr in the same cycle as the lookup result that should have changed it.
- A lost clear shows on the cycle after irq_clr.
- A log that is overwritten too early shows after a second bad word is looked up.

// File: rtl/vlanf_pkg.sv
package vlanf_pkg;
    parameter int VID_W  = 12;
    parameter int WORD_W = 32;
    localparam int BYTES = WORD_W / 8;
    localparam int WORDS = (1 << VID_W) / WORD_W;
    localparam int AW    = $clog2(WORDS);
    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [BYTES-1:0]  par;
        logic [WORD_W-1:0] member;
    } entry_t;

    typedef struct packed {
        logic             chk_en;
        logic             dbg_wr;
        logic             imp_valid;
        logic [VID_W-1:0] imp_vid;
    } ctrl_t;

    // One parity bit per byte; byte plus its parity bit hold an odd count of ones
    function automatic logic [BYTES-1:0] odd_par(input logic [WORD_W-1:0] d);
        logic [BYTES-1:0] p;
        for (int i = 0; i < BYTES; i++) begin
            p[i] = ~^d[8*i +: 8];
        end
        return p;
    endfunction
endpackage

// File: rtl/vlanf_table.sv
module vlanf_table
    import vlanf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              dbg_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] wr_member,
    input  logic [BYTES-1:0]  wr_par,
    output entry_t            host_q,
    input  logic [AW-1:0]     lk_addr,
    output entry_t            lk_entry
);
    entry_t mem [WORDS];
    entry_t wr_entry;

    always_comb begin
        wr_entry.member = wr_member;
        wr_entry.par    = dbg_wr ? wr_par : odd_par(wr_member);
    end

    // Combinational lookup read sees contents before this cycle's write
    assign lk_entry = mem[lk_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[host_addr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_q <= '0;
        end else begin
            host_q <= mem[host_addr];
        end
    end
endmodule

// File: rtl/vlanf_lookup.sv
module vlanf_lookup
    import vlanf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             untagged,
    input  logic [VID_W-1:0] vid,
    input  logic             chk_en,
    input  logic             imp_valid,
    input  logic [VID_W-1:0] imp_vid,
    output logic [AW-1:0]    word_addr,
    input  entry_t           entry,
    output logic             err_pulse,
    output logic             lk_valid,
    output logic             lk_member,
    output logic             lk_par_err
);
    logic [VID_W-1:0] eff_vid;
    logic [BIT_W-1:0] bit_sel;
    logic             bypass;
    logic             bad_word;

    always_comb begin
        eff_vid   = untagged ? imp_vid : vid;
        bypass    = untagged && !imp_valid;
        word_addr = eff_vid[VID_W-1:BIT_W];
        bit_sel   = eff_vid[BIT_W-1:0];
        bad_word  = chk_en && (odd_par(entry.member) != entry.par);
        err_pulse = req && !bypass && bad_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_valid   <= 1'b0;
            lk_member  <= 1'b0;
            lk_par_err <= 1'b0;
        end else begin
            lk_valid   <= req;
            lk_member  <= bypass ? 1'b1 : entry.member[bit_sel];
            lk_par_err <= err_pulse;
        end
    end

    // R6
    untag_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req && untagged && !imp_valid) |=> (lk_valid && lk_member && !lk_par_err));

    // R4
    chk_off_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !chk_en) |=> !lk_par_err);
endmodule

// File: rtl/vlanf_errlog.sv
module vlanf_errlog
    import vlanf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             err_pulse,
    input  logic [AW-1:0]    err_addr,
    input  logic             clr,
    output logic             irq,
    output logic [VID_W-1:0] log_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            log_addr <= '0;
        end else if (err_pulse && (!irq || clr)) begin
            irq      <= 1'b1;
            log_addr <= {{(VID_W-AW){1'b0}}, err_addr};
        end else if (clr) begin
            irq      <= 1'b0;
            log_addr <= '0;
        end
    end

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    // R8
    log_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> $stable(log_addr));

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !err_pulse) |=> (!irq && log_addr == '0));

    // R7
    set_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> irq);
endmodule

// File: rtl/vlan_member_filter.sv
module vlan_member_filter
    import vlanf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wr_member,
    input  logic [BYTES-1:0]  host_wr_par,
    output logic [WORD_W-1:0] host_rd_member,
    output logic [BYTES-1:0]  host_rd_par,
    input  logic              cfg_wr_en,
    input  logic              cfg_chk_en,
    input  logic              cfg_dbg_wr,
    input  logic              cfg_imp_valid,
    input  logic [VID_W-1:0]  cfg_imp_vid,
    input  logic              irq_clr,
    input  logic              lk_req,
    input  logic              lk_untagged,
    input  logic [VID_W-1:0]  lk_vid,
    output logic              lk_valid,
    output logic              lk_member,
    output logic              lk_par_err,
    output logic              par_irq,
    output logic [VID_W-1:0]  par_log_addr
);
    ctrl_t         ctrl;
    entry_t        host_q;
    entry_t        lk_entry;
    logic [AW-1:0] lk_word;
    logic          err_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (cfg_wr_en) begin
            ctrl.chk_en    <= cfg_chk_en;
            ctrl.dbg_wr    <= cfg_dbg_wr;
            ctrl.imp_valid <= cfg_imp_valid;
            ctrl.imp_vid   <= cfg_imp_vid;
        end
    end

    vlanf_table u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr_en),
        .dbg_wr    (ctrl.dbg_wr),
        .host_addr (host_addr),
        .wr_member (host_wr_member),
        .wr_par    (host_wr_par),
        .host_q    (host_q),
        .lk_addr   (lk_word),
        .lk_entry  (lk_entry)
    );

    vlanf_lookup u_lookup (
        .clk        (clk),
        .rst        (rst),
        .req        (lk_req),
        .untagged   (lk_untagged),
        .vid        (lk_vid),
        .chk_en     (ctrl.chk_en),
        .imp_valid  (ctrl.imp_valid),
        .imp_vid    (ctrl.imp_vid),
        .word_addr  (lk_word),
        .entry      (lk_entry),
        .err_pulse  (err_pulse),
        .lk_valid   (lk_valid),
        .lk_member  (lk_member),
        .lk_par_err (lk_par_err)
    );

    vlanf_errlog u_errlog (
        .clk      (clk),
        .rst      (rst),
        .err_pulse(err_pulse),
        .err_addr (lk_word),
        .clr      (irq_clr),
        .irq      (par_irq),
        .log_addr (par_log_addr)
    );

    assign host_rd_member = host_q.member;
    assign host_rd_par    = host_q.par;

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!lk_valid && !par_irq && par_log_addr == '0));
endmodule

// File: tb/tb_vlan_member_filter.sv
module tb_vlan_member_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_en = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [31:0] host_wr_member = '0;
    logic [3:0]  host_wr_par = '0;
    logic [31:0] host_rd_member;
    logic [3:0]  host_rd_par;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_chk_en = 1'b0;
    logic        cfg_dbg_wr = 1'b0;
    logic        cfg_imp_valid = 1'b0;
    logic [11:0] cfg_imp_vid = '0;
    logic        irq_clr = 1'b0;
    logic        lk_req = 1'b0;
    logic        lk_untagged = 1'b0;
    logic [11:0] lk_vid = '0;
    logic        lk_valid, lk_member, lk_par_err, par_irq;
    logic [11:0] par_log_addr;

    always #2 clk = ~clk;

    vlan_member_filter dut (.*);

    // bench model state
    logic [31:0] sh_mem [128];
    logic [3:0]  sh_par [128];
    logic        m_chk = 1'b0, m_dbg = 1'b0, m_imp_valid = 1'b0;
    logic [11:0] m_imp_vid = '0;
    logic [1:0]  exp_q [$];
    string       tag_q [$];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    function automatic logic [3:0] bpar(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ((d >> (8*i)) & 32'hFF) == 0 ? 1'b1 : ~^d[8*i +: 8];
        return p;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // scoreboard driver: compute expectation and drive request (no clock advance)
    task automatic push_lookup(input logic untag, input logic [11:0] vid, input string tag);
        logic [11:0] ev;
        logic [1:0]  e;
        ev = untag ? m_imp_vid : vid;
        if (untag && !m_imp_valid) e = 2'b10;
        else e = {sh_mem[ev[11:5]][ev[4:0]],
                  m_chk && (bpar(sh_mem[ev[11:5]]) != sh_par[ev[11:5]])};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        lk_req = 1'b1;
        lk_untagged = untag;
        lk_vid = vid;
    endtask

    task automatic do_lookup(input logic untag, input logic [11:0] vid, input string tag);
        push_lookup(untag, vid, tag);
        tick();
        lk_req = 1'b0;
    endtask

    task automatic drive_write(input logic [6:0] a, input logic [31:0] m, input logic [3:0] p);
        host_wr_en = 1'b1;
        host_addr = a;
        host_wr_member = m;
        host_wr_par = p;
        sh_mem[a] = m;
        sh_par[a] = m_dbg ? p : bpar(m);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] m, input logic [3:0] p);
        drive_write(a, m, p);
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic do_cfg(input logic chk, input logic dbg, input logic iv, input logic [11:0] vid);
        cfg_wr_en = 1'b1;
        cfg_chk_en = chk; cfg_dbg_wr = dbg; cfg_imp_valid = iv; cfg_imp_vid = vid;
        m_chk = chk; m_dbg = dbg; m_imp_valid = iv; m_imp_vid = vid;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [6:0] a, input logic [31:0] em, input logic [3:0] ep,
                             input string tag);
        host_addr = a;
        tick();
        @(negedge clk);
        check({tag, " rd_member"}, host_rd_member, em);
        check({tag, " rd_par"}, {28'h0, host_rd_par}, {28'h0, ep});
        tick();
    endtask

    // monitor: pops expectations as results come out
    always @(negedge clk) begin
        if (!rst && lk_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected lk_valid", 32'd1, 32'd0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " member"}, {31'h0, lk_member}, {31'h0, e[1]});
                check({t, " par_err"}, {31'h0, lk_par_err}, {31'h0, e[0]});
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        report();
    end

    initial begin
        logic [31:0] oldw;
        logic [11:0] v0, v1;
        bit f0, f1;
        repeat (3) tick();
        // R11 reset state
        check("R11 lk_valid", {31'h0, lk_valid}, 32'h0);
        check("R11 par_irq", {31'h0, par_irq}, 32'h0);
        check("R11 log", {20'h0, par_log_addr}, 32'h0);
        rst = 1'b0;
        tick();
        // fill table with hardware-generated parity
        for (int n = 0; n < 128; n++) do_write(7'(n), 32'h9E3779B9 * (n + 1), 4'h0);
        // R2 readback
        host_read(7'd3, sh_mem[3], bpar(sh_mem[3]), "R2 w3");
        host_read(7'd77, sh_mem[77], bpar(sh_mem[77]), "R2 w77");
        // R11 check-off default, R4 no error with check off
        do_lookup(1'b0, 12'd40, "R4 chk off");
        do_cfg(1'b1, 1'b0, 1'b0, 12'd0);
        // R1 tagged lookups
        do_lookup(1'b0, 12'd0, "R1 vid0");
        do_lookup(1'b0, 12'd31, "R1 vid31");
        do_lookup(1'b0, 12'd32, "R1 vid32");
        do_lookup(1'b0, 12'd1234, "R1 vid1234");
        do_lookup(1'b0, 12'd4095, "R1 vid4095");
        for (int k = 0; k < 8; k++) do_lookup(1'b0, 12'(k * 517 + 3), "R1 sweep");
        // R6 untagged with implicit invalid
        do_lookup(1'b1, 12'd100, "R6 untagged pass");
        // R5 implicit id: find a member and non-member vid
        f0 = 0; f1 = 0; v0 = 0; v1 = 0;
        for (int v = 0; v < 4096; v++) begin
            if (!f0 && !sh_mem[v >> 5][v & 31]) begin v0 = 12'(v); f0 = 1; end
            if (!f1 &&  sh_mem[v >> 5][v & 31]) begin v1 = 12'(v); f1 = 1; end
        end
        do_cfg(1'b1, 1'b0, 1'b1, v0);
        do_lookup(1'b1, v1, "R5 implicit non-member");
        do_cfg(1'b1, 1'b0, 1'b1, v1);
        do_lookup(1'b1, v0, "R5 implicit member");
        // R3 debug write with bad parity
        do_cfg(1'b1, 1'b1, 1'b0, 12'd0);
        do_write(7'd5, 32'h00FF_1234, bpar(32'h00FF_1234) ^ 4'b0001);
        do_write(7'd9, 32'hA5A5_0001, bpar(32'hA5A5_0001) ^ 4'b1000);
        do_cfg(1'b1, 1'b0, 1'b0, 12'd0);
        host_read(7'd5, 32'h00FF_1234, bpar(32'h00FF_1234) ^ 4'b0001, "R3 w5");
        // R4/R7 error detection and logging
        do_lookup(1'b0, 12'(5*32 + 3), "R4 bad w5");
        @(negedge clk);
        check("R7 irq set", {31'h0, par_irq}, 32'h1);
        check("R7 log w5", {20'h0, par_log_addr}, 32'd5);
        tick();
        // R8 second error does not overwrite log
        do_lookup(1'b0, 12'(9*32), "R4 bad w9");
        @(negedge clk);
        check("R8 irq held", {31'h0, par_irq}, 32'h1);
        check("R8 log held", {20'h0, par_log_addr}, 32'd5);
        tick();
        // R4 check off masks error
        do_cfg(1'b0, 1'b0, 1'b0, 12'd0);
        do_lookup(1'b0, 12'(5*32 + 3), "R4 chk off bad w5");
        do_cfg(1'b1, 1'b0, 1'b0, 12'd0);
        // R9 clear
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
        @(negedge clk);
        check("R9 irq cleared", {31'h0, par_irq}, 32'h0);
        check("R9 log cleared", {20'h0, par_log_addr}, 32'd0);
        tick();
        do_lookup(1'b0, 12'(9*32 + 1), "R4 bad w9 again");
        @(negedge clk);
        check("R7 log w9", {20'h0, par_log_addr}, 32'd9);
        tick();
        // R9 clear and error in same cycle: error wins
        irq_clr = 1'b1;
        do_lookup(1'b0, 12'(5*32), "R4 bad w5 with clear");
        irq_clr = 1'b0;
        @(negedge clk);
        check("R9 err wins irq", {31'h0, par_irq}, 32'h1);
        check("R9 err wins log", {20'h0, par_log_addr}, 32'd5);
        tick();
        // R10 same-cycle write and lookup
        oldw = sh_mem[20];
        push_lookup(1'b0, 12'(20*32 + 7), "R10 old data");
        drive_write(7'd20, ~oldw, 4'h0);
        tick();
        lk_req = 1'b0;
        host_wr_en = 1'b0;
        @(negedge clk);
        check("R10 host read old", host_rd_member, oldw);
        tick();
        do_lookup(1'b0, 12'(20*32 + 7), "R10 new data");
        repeat (4) tick();
        check("R1 all results seen", exp_q.size(), 32'd0);
        report();
    end
endmodule